// File: doc/BRIEF.md
# Dual-Enable Word Memory with Half-Word Masking

This block is a clocked, synthesizable model of a 32-bit-wide static memory whose control port behaves like an asynchronous SRAM. Two chip enables of opposite polarity select it, an active-low write strobe picks between storing and fetching, and an active-low output enable gates the read path. Two active-low half-word enables, one for bits 31:16 and one for bits 15:0, let each 16-bit half take part in a cycle or stay out of it independently.

The data bus is split into a write-data input and a read-data output. Two drive flags, one for each half, stand in for the tri-state drivers of a bidirectional bus, so a controller under test can be checked for bus ownership without resolved nets. A half that is not driven reads as zero. Writes are committed on the rising clock edge. Reads are combinational, so the stored word appears in the same cycle as its address. The depth is set by an address-width parameter. The default is kept small so that elaboration stays cheap, and it can be raised to 17 bits for the full 128K-word array. Memory content is not cleared by reset.

Top module: `hwsram_top`

## Requirements
- R1: When `ce1_n` is 1 or `ce2` is 0, both drive flags are 0, `rdata` is all zero, and no location is written, whatever the other inputs are.
- R2: When selected (`ce1_n`=0, `ce2`=1) with `we_n`=0, `hw_hi_n`=0 and `hw_lo_n`=0, all 32 bits of `wdata` are stored at `addr` on the rising clock edge.
- R3: When selected with `we_n`=0, `hw_lo_n`=0 and `hw_hi_n`=1, only bits 15:0 are stored, and bits 31:16 of that location keep their old value.
- R4: When selected with `we_n`=0, `hw_hi_n`=0 and `hw_lo_n`=1, only bits 31:16 are stored, and bits 15:0 keep their old value.
- R5: When `hw_hi_n` and `hw_lo_n` are both 1, nothing is written and neither drive flag is set.
- R6: When selected with `we_n`=1 and `oe_n`=0, `drv_hi` equals the inverse of `hw_hi_n`, `drv_lo` equals the inverse of `hw_lo_n`, and each driven half of `rdata` shows the stored content of `addr` in the same cycle. A write is visible from the cycle after its clock edge.
- R7: When selected with `we_n`=1 and `oe_n`=1, both drive flags are 0.
- R8: During any selected write (`we_n`=0), both drive flags are 0, whatever the value of `oe_n`.
- R9: A half of `rdata` whose drive flag is 0 reads as zero (bits 31:16 for `drv_hi`, bits 15:0 for `drv_lo`).
- R10: Writes are blocked while `rst_n` is 0 and for the first two rising clock edges after it is released. Stored content is kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| hw_hi_n | input | 1 | Upper half-word enable (bits 31:16), active low |
| hw_lo_n | input | 1 | Lower half-word enable (bits 15:0), active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; undriven halves are zero |
| drv_hi | output | 1 | Upper half would be driving the bus |
| drv_lo | output | 1 | Lower half would be driving the bus |

## Verification
The hardest case to reach from the ports is the write blocked in the two clock edges right after reset release. Content written before reset has to survive, and a write attempted on the first edge after release must leave no trace. The bench first stores a known word. It then pulses reset, offers a conflicting write at that address during reset and again on the first edge after release, and finally reads the location back. Partial writes are checked in the same way, by stacking low-only and high-only writes on top of a full word and reading back each half alone.

// File: rtl/hwsram_pkg.sv
package hwsram_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_HALVES = 2;
  localparam int HALF_W     = WORD_W / NUM_HALVES;

  // per-half control decoded from the port truth table
  typedef struct packed {
    logic wr;   // store this half on the coming edge
    logic drv;  // this half owns the read bus
  } half_ctl_t;
endpackage

// File: rtl/hwsram_ctl.sv
module hwsram_ctl
  import hwsram_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce1_n,
  input  logic                        ce2,
  input  logic                        we_n,
  input  logic                        oe_n,
  input  logic [NUM_HALVES-1:0]       half_n,
  output half_ctl_t [NUM_HALVES-1:0]  ctl
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] run_q, run_d;
  logic                run;
  logic                sel;

  // reset release synchroniser: writes held off until it fills
  always_comb run_d = {run_q[SYNC_LEN-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign run = run_q[SYNC_LEN-1];
  assign sel = !ce1_n && ce2;

  always_comb begin
    for (int h = 0; h < NUM_HALVES; h++) begin
      ctl[h].wr  = sel && !we_n && !half_n[h] && run;
      ctl[h].drv = sel &&  we_n && !oe_n && !half_n[h];
    end
  end

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n || !ce2) |-> (ctl == '0));

  assert_halves_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&half_n) |-> (ctl == '0));

  assert_oe_gates_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n) |-> (ctl[0].drv == 1'b0 && ctl[1].drv == 1'b0));

  assert_no_drive_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |-> (ctl[0].drv == 1'b0 && ctl[1].drv == 1'b0));

  assert_startup_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |-> (ctl[0].wr == 1'b0 && ctl[1].wr == 1'b0));
endmodule

// File: rtl/hwsram_bank.sv
module hwsram_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // content is deliberately left uninitialised and never cleared
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/hwsram_top.sv
module hwsram_top
  import hwsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              hw_hi_n,
  input  logic              hw_lo_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              drv_hi,
  output logic              drv_lo
);
  half_ctl_t [NUM_HALVES-1:0] ctl;
  logic [NUM_HALVES-1:0]      half_n;

  assign half_n = {hw_hi_n, hw_lo_n};

  hwsram_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .half_n (half_n),
    .ctl    (ctl)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] bank_q;

    hwsram_bank #(.DATA_W(HALF_W), .ADDR_W(ADDR_W)) u_bank (
      .clk   (clk),
      .wen   (ctl[h].wr),
      .addr  (addr),
      .wdata (wdata[h*HALF_W +: HALF_W]),
      .rdata (bank_q)
    );

    assign rdata[h*HALF_W +: HALF_W] = ctl[h].drv ? bank_q : '0;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[h].wr ##1 ($stable(addr) && ctl[h].drv)
      |-> (rdata[h*HALF_W +: HALF_W] == $past(wdata[h*HALF_W +: HALF_W])));

    assert_idle_half_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[h].drv |-> (rdata[h*HALF_W +: HALF_W] == '0));
  end

  assign drv_lo = ctl[0].drv;
  assign drv_hi = ctl[1].drv;
endmodule

// File: tb/tb_hwsram_top.sv
module tb_hwsram_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce1_n, ce2, we_n, oe_n, hw_hi_n, hw_lo_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          drv_hi, drv_lo;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hwsram_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n),
    .oe_n(oe_n), .hw_hi_n(hw_hi_n), .hw_lo_n(hw_lo_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one cycle of controls at the falling edge, settle 2 ns
  task automatic put(input logic c1n, input logic c2, input logic wn, input logic on,
                     input logic hn, input logic ln, input logic [AW-1:0] a,
                     input logic [31:0] d);
    @(negedge clk);
    ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on;
    hw_hi_n = hn; hw_lo_n = ln; addr = a; wdata = d;
    #2;
  endtask

  task automatic idle();
    put(1, 0, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic rd_full(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    put(0, 1, 1, 0, 0, 0, a, 32'h0);
    chk(tag, rdata, exp);
  endtask

  task automatic t_reset_state();
    idle();
    chk("R1 reset idle flags", {30'd0, drv_hi, drv_lo}, 32'd0);
    chk("R1 reset idle rdata", rdata, 32'd0);
  endtask

  task automatic t_full_write();
    put(0, 1, 0, 1, 0, 0, 10'd3, 32'hA5A5_1234);
    rd_full(10'd3, 32'hA5A5_1234, "R2 full word write");
    chk("R6 read flags", {30'd0, drv_hi, drv_lo}, 32'd3);
  endtask

  task automatic t_low_write();
    put(0, 1, 0, 1, 1, 0, 10'd3, 32'hFFFF_BEEF);
    rd_full(10'd3, 32'hA5A5_BEEF, "R3 low half write");
  endtask

  task automatic t_high_write();
    put(0, 1, 0, 1, 0, 1, 10'd3, 32'h7777_0000);
    rd_full(10'd3, 32'h7777_BEEF, "R4 high half write");
  endtask

  task automatic t_no_halves();
    put(0, 1, 0, 0, 1, 1, 10'd3, 32'h0000_0000);
    chk("R5 no drive when halves off", {30'd0, drv_hi, drv_lo}, 32'd0);
    put(0, 1, 1, 0, 1, 1, 10'd3, 32'h0);
    chk("R5 read with halves off", {rdata[31:2], drv_hi, drv_lo}, 32'd0);
    rd_full(10'd3, 32'h7777_BEEF, "R5 write disabled");
  endtask

  task automatic t_half_reads();
    put(0, 1, 1, 0, 1, 0, 10'd3, 32'h0);
    chk("R6 low read flags", {30'd0, drv_hi, drv_lo}, 32'd1);
    chk("R9 low read data", rdata, 32'h0000_BEEF);
    put(0, 1, 1, 0, 0, 1, 10'd3, 32'h0);
    chk("R6 high read flags", {30'd0, drv_hi, drv_lo}, 32'd2);
    chk("R9 high read data", rdata, 32'h7777_0000);
  endtask

  task automatic t_oe_off();
    put(0, 1, 1, 1, 0, 0, 10'd3, 32'h0);
    chk("R7 oe high flags", {30'd0, drv_hi, drv_lo}, 32'd0);
    chk("R7 oe high rdata", rdata, 32'd0);
  endtask

  task automatic t_write_no_drive();
    put(0, 1, 0, 0, 0, 0, 10'd9, 32'h1357_9BDF);
    chk("R8 write with oe low flags", {30'd0, drv_hi, drv_lo}, 32'd0);
    rd_full(10'd9, 32'h1357_9BDF, "R6 read right after write");
    rd_full(10'd3, 32'h7777_BEEF, "R6 other address intact");
  endtask

  task automatic t_deselect();
    put(0, 0, 0, 0, 0, 0, 10'd9, 32'hDEAD_0001);
    chk("R1 ce2 low flags", {30'd0, drv_hi, drv_lo}, 32'd0);
    put(1, 1, 0, 0, 0, 0, 10'd9, 32'hDEAD_0002);
    chk("R1 ce1 high flags", {30'd0, drv_hi, drv_lo}, 32'd0);
    put(1, 1, 1, 0, 0, 0, 10'd9, 32'h0);
    chk("R1 deselected read rdata", rdata, 32'd0);
    rd_full(10'd9, 32'h1357_9BDF, "R1 deselected writes ignored");
  endtask

  task automatic t_reset_hold();
    put(0, 1, 0, 1, 0, 0, 10'd20, 32'hCAFE_F00D);
    rd_full(10'd20, 32'hCAFE_F00D, "R10 setup word");
    @(negedge clk);
    rst_n = 1'b0;
    put(0, 1, 0, 1, 0, 0, 10'd20, 32'h1111_1111);
    @(negedge clk);
    rst_n = 1'b1;
    // first edge after release: write must still be blocked
    ce1_n = 0; ce2 = 1; we_n = 0; oe_n = 1; hw_hi_n = 0; hw_lo_n = 0;
    addr = 10'd20; wdata = 32'h2222_2222;
    rd_full(10'd20, 32'hCAFE_F00D, "R10 held across reset");
  endtask

  initial begin
    rst_n = 1'b0;
    ce1_n = 1; ce2 = 0; we_n = 1; oe_n = 1; hw_hi_n = 1; hw_lo_n = 1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    t_reset_state();
    t_full_write();
    t_low_write();
    t_high_write();
    t_no_halves();
    t_half_reads();
    t_oe_off();
    t_write_no_drive();
    t_deselect();
    t_reset_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule